// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block keeps exception bookkeeping in step with a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A stage that detects a problem with its instruction does not act on it. It raises a flag, and the block records that flag beside the instruction's PC. The record moves down through the decode, execute and memory registers together with the instruction. The block decides only at the memory stage, which is the commit point. If the instruction there carries any recorded fault, raises a data-address fault in that cycle, or meets a pending interrupt request, the block takes the trap. Because every decision is made at this one point, the oldest instruction in flight always wins.

When it takes a trap, the block asserts kills to fetch, decode and execute in the same cycle and blocks the writeback of the instruction at the commit point. It also tells the PC mux to select the handler address. On the next clock edge it stores the PC of that instruction in the exception PC register and the reason in the cause register. An interrupt is charged to the instruction at the commit point, which is killed along with the rest. Execution therefore resumes at that instruction's PC.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every kill output and the handler select are low, and the exception PC and cause read 0.
- R2: A trap is taken in a cycle when the memory stage holds a valid instruction that carries a recorded fault, or raises a data-address fault in that cycle, or meets an asserted interrupt request. In that cycle kill_f_o, kill_d_o, kill_e_o, kill_wb_o and handler_sel_o are all high. In every other cycle all of them are low.
- R3: No trap is taken when the memory stage holds no valid instruction, even while the interrupt request is high. A fault flag is ignored when it is raised for a slot that holds no valid instruction.
- R4: One cycle after a trap, epc_o holds the PC that the committing instruction had when it was fetched.
- R5: Cause codes are 1 for a fetch fault, 2 for an illegal opcode, 3 for arithmetic overflow, 4 for a data-address fault and 5 for an interrupt. When one instruction carries several faults, the fault raised in the earliest stage is recorded.
- R6: A synchronous fault on the committing instruction takes priority over a simultaneous interrupt, and cause reads that fault's code.
- R7: Instructions killed by a trap never commit their flags. In the cycle after a trap no trap is taken, even with the interrupt request high.
- R8: In a cycle without a trap, epc_o and cause_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| f_valid_i | input | 1 | Fetch stage holds a valid instruction |
| f_pc_i | input | PC_W | PC of the instruction in fetch |
| f_fault_i | input | 1 | Instruction-address fault for the fetch instruction |
| d_illegal_i | input | 1 | Illegal opcode for the decode instruction |
| e_ovf_i | input | 1 | Arithmetic overflow for the execute instruction |
| m_fault_i | input | 1 | Data-address fault for the memory-stage instruction |
| irq_i | input | 1 | Asynchronous interrupt request, level |
| kill_f_o | output | 1 | Squash the fetch stage |
| kill_d_o | output | 1 | Squash the decode stage |
| kill_e_o | output | 1 | Squash the execute stage |
| kill_wb_o | output | 1 | Suppress writeback of the committing instruction |
| handler_sel_o | output | 1 | Select the handler address as the next PC |
| epc_o | output | PC_W | PC of the last trapping instruction |
| cause_o | output | 3 | Cause code of the last trap |

## Verification
The bench runs an instruction through the pipe with every combination of fetch, decode, execute and memory faults, once with the interrupt request asserted and once without. A younger instruction carrying its own fetch fault follows one slot behind. If the priority were wrong, cause would show a later stage's code or an interrupt in place of a fault. If the record did not carry the PC correctly, epc would hold the younger instruction's PC. If killed instructions were not flushed, the younger fault would trap in the cycle right after the first trap. Idle cycles keep the interrupt request high while fault flags are raised for empty slots. A design that trapped on an empty commit point or recorded a flag for an invalid slot would fire there.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W   = 3;
  localparam int NUM_CARRY = 3;  // records held in D, E and M

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE    = 3'd0,
    C_FETCH   = 3'd1,
    C_ILLEGAL = 3'd2,
    C_OVF     = 3'd3,
    C_DMEM    = 3'd4,
    C_IRQ     = 3'd5
  } cause_e;

  // code recorded while entering carried stage s (0: F->D, 1: D->E, 2: E->M)
  function automatic cause_e raise_code(int s);
    case (s)
      0:       return C_FETCH;
      1:       return C_ILLEGAL;
      default: return C_OVF;
    endcase
  endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int     PC_W = 32,
  parameter cause_e RAISE = C_FETCH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            v_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          code_i,
  input  logic            raise_i,
  output logic            v_o,
  output logic [PC_W-1:0] pc_o,
  output cause_e          code_o
);
  cause_e code_d;

  // an older code is kept, so the earliest stage wins
  always_comb begin
    if (!v_i)                code_d = C_NONE;
    else if (code_i != C_NONE) code_d = code_i;
    else if (raise_i)        code_d = RAISE;
    else                     code_d = C_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      pc_o   <= '0;
      code_o <= C_NONE;
    end else begin
      v_o    <= v_i && !flush_i;
      pc_o   <= pc_i;
      code_o <= flush_i ? C_NONE : code_d;
    end
  end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
(
  input  logic   m_v_i,
  input  cause_e m_code_i,
  input  logic   m_fault_i,
  input  logic   irq_i,
  output logic   take_o,
  output cause_e cause_o
);
  always_comb begin
    cause_o = C_NONE;
    if (m_v_i) begin
      if (m_code_i != C_NONE) cause_o = m_code_i;
      else if (m_fault_i)     cause_o = C_DMEM;
      else if (irq_i)         cause_o = C_IRQ;
    end
    take_o = (cause_o != C_NONE);
  end
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [PC_W-1:0]    pc_i,
  input  cause_e             cause_i,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (take_i) begin
      epc_o   <= pc_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               f_valid_i,
  input  logic [PC_W-1:0]    f_pc_i,
  input  logic               f_fault_i,
  input  logic               d_illegal_i,
  input  logic               e_ovf_i,
  input  logic               m_fault_i,
  input  logic               irq_i,
  output logic               kill_f_o,
  output logic               kill_d_o,
  output logic               kill_e_o,
  output logic               kill_wb_o,
  output logic               handler_sel_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_CARRY:0] v;
  logic [PC_W-1:0]    pc   [NUM_CARRY+1];
  cause_e             code [NUM_CARRY+1];
  logic [NUM_CARRY-1:0] raise;
  logic   take;
  cause_e take_cause;

  logic            m_v;
  logic [PC_W-1:0] m_pc;
  cause_e          m_code;

  assign v[0]    = f_valid_i;
  assign pc[0]   = f_pc_i;
  assign code[0] = C_NONE;
  assign raise   = {e_ovf_i, d_illegal_i, f_fault_i};

  for (genvar s = 0; s < NUM_CARRY; s++) begin : g_carry
    exc_stage_reg #(
      .PC_W (PC_W),
      .RAISE(raise_code(s))
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(take),
      .v_i    (v[s]),
      .pc_i   (pc[s]),
      .code_i (code[s]),
      .raise_i(raise[s]),
      .v_o    (v[s+1]),
      .pc_o   (pc[s+1]),
      .code_o (code[s+1])
    );
  end

  assign m_v    = v[NUM_CARRY];
  assign m_pc   = pc[NUM_CARRY];
  assign m_code = code[NUM_CARRY];

  exc_commit_unit u_commit (
    .m_v_i    (m_v),
    .m_code_i (m_code),
    .m_fault_i(m_fault_i),
    .irq_i    (irq_i),
    .take_o   (take),
    .cause_o  (take_cause)
  );

  exc_status_regs #(.PC_W(PC_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .pc_i   (m_pc),
    .cause_i(take_cause),
    .epc_o  (epc_o),
    .cause_o(cause_o)
  );

  assign kill_f_o      = take;
  assign kill_d_o      = take;
  assign kill_e_o      = take;
  assign kill_wb_o     = take;
  assign handler_sel_o = take;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            m_v_i,
  input logic [PC_W-1:0] m_pc_i,
  input logic [2:0]      m_code_i,
  input logic            take_i,
  input logic [PC_W-1:0] epc_i,
  input logic [2:0]      cause_i
);
  a_r3_idle_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_v_i |-> !take_i);
  a_r4_epc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> epc_i == $past(m_pc_i));
  a_r5_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> cause_i != 3'd0);
  a_r6_fault_over_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && m_code_i != 3'd0) |=> cause_i == $past(m_code_i));
  a_r7_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !take_i);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(epc_i) && $stable(cause_i));
endmodule

bind exc_commit_ctrl exc_commit_chk #(.PC_W(PC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .m_v_i   (m_v),
  .m_pc_i  (m_pc),
  .m_code_i(m_code),
  .take_i  (handler_sel_o),
  .epc_i   (epc_o),
  .cause_i (cause_o)
);

// File: tb/sim_exc_commit_ctrl.sv
module sim_exc_commit_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic f_valid, f_fault, d_illegal, e_ovf, m_fault, irq;
  logic [PC_W-1:0] f_pc;
  logic kill_f, kill_d, kill_e, kill_wb, hsel;
  logic [PC_W-1:0] epc;
  logic [2:0] cause;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [PC_W-1:0] exp_epc = '0;
  logic [2:0] exp_cause = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_commit_ctrl #(.PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .f_valid_i(f_valid), .f_pc_i(f_pc), .f_fault_i(f_fault),
    .d_illegal_i(d_illegal), .e_ovf_i(e_ovf), .m_fault_i(m_fault), .irq_i(irq),
    .kill_f_o(kill_f), .kill_d_o(kill_d), .kill_e_o(kill_e), .kill_wb_o(kill_wb),
    .handler_sel_o(hsel), .epc_o(epc), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_kills(input string req, input logic e);
    chk(req, int'({kill_f, kill_d, kill_e, kill_wb, hsel}), e ? 31 : 0);
  endtask

  task automatic chk_status(input string req);
    chk({req, " epc"}, int'(epc), int'(exp_epc));
    chk({req, " cause"}, int'(cause), int'(exp_cause));
  endtask

  task automatic drive(input logic fv, input logic [PC_W-1:0] pc, input logic ff,
                       input logic di, input logic eo, input logic mf, input logic ir);
    f_valid = fv; f_pc = pc; f_fault = ff; d_illegal = di;
    e_ovf = eo; m_fault = mf; irq = ir;
  endtask

  task automatic scenario(input int mask, input logic ir, input logic [PC_W-1:0] p);
    logic took;
    logic [2:0] c;
    // R3: empty pipe, irq high, faults flagged on invalid slots
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 8'hEE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      #1 chk_kills("R3 idle", 1'b0);
      @(negedge clk);
    end
    drive(1'b1, p, mask[0], 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, p + 8'd4, 1'b1, mask[1], 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 8'h00, 1'b0, 1'b0, mask[2], 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, mask[3], ir);
    // R5/R6 expected cause: lowest set stage bit wins, irq last
    if (mask[0]) c = 3'd1;
    else if (mask[1]) c = 3'd2;
    else if (mask[2]) c = 3'd3;
    else if (mask[3]) c = 3'd4;
    else if (ir) c = 3'd5;
    else c = 3'd0;
    took = (c != 3'd0);
    #1 chk_kills("R2 commit kills", took);
    @(negedge clk);
    if (took) begin exp_epc = p; exp_cause = c; end
    if (took) chk_status("R4 R5 R6 trap record");
    else chk_status("R8 hold");
    // younger instruction (fetch fault) now at commit, irq high
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    #1 chk_kills("R7 younger", !took);
    @(negedge clk);
    if (!took) begin exp_epc = p + 8'd4; exp_cause = 3'd1; end
    chk_status("R7 R5 younger record");
  endtask

  initial begin
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #2;
    chk_kills("R1 in reset", 1'b0);
    chk_status("R1 in reset");
    #(3*CLK_PERIOD);
    @(negedge clk);
    rst_ni = 1'b1;
    #1 chk_kills("R1 after reset", 1'b0);
    chk_status("R1 after reset");
    @(negedge clk);
    for (int ir = 0; ir < 2; ir++)
      for (int m = 0; m < 16; m++)
        scenario(m, ir[0], 8'((ir * 16 + m) * 8 + 16));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule